// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a word-granular direct-mapped cache that keeps a small fully associative victim buffer next to it. Every request first probes the direct-mapped array. Only when that probe misses does the victim buffer's answer count. A request that hits the victim buffer exchanges the two lines in one extra cycle. The buffer's line goes into the direct-mapped slot, and the line that sat there takes the freed buffer entry. A request that misses both stores reads the word from a next-level memory port. The line it displaces from the direct-mapped array is pushed into the victim buffer, which may in turn push out one of its own entries.

Stores are write-back. A dirty flag follows each line wherever it moves. The next-level memory sees a write only when a dirty line falls out of the victim buffer. A clean line leaving the buffer is discarded. Each buffer entry keeps the line's full word address, because the buffer has no index. The requester handshakes with `req_valid`/`req_ready` and gets back a one-cycle `resp_valid` pulse. It keeps at most one request outstanding after a miss.

Top module: `dmvc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid`, `mem_rd_req` and `mem_wr_valid` are 0, and both stores are empty, so the first request of any address reads next-level memory.
- R2: A request that hits the direct-mapped array produces `resp_valid` in the cycle after acceptance, with no memory read.
- R3: A request that misses the direct-mapped array but hits the victim buffer produces `resp_valid` two cycles after acceptance, with no memory read. The displaced direct-mapped line becomes a victim-buffer hit afterwards.
- R4: A request that misses both stores raises `mem_rd_req` with the request's word address and produces `resp_valid` in the cycle after `mem_rd_valid`. The direct-mapped line it displaces, if valid, enters the victim buffer.
- R5: The victim buffer has 4 entries numbered 0 to 3. An incoming line takes the lowest-numbered free entry. When none is free, it takes the entry named by a round-robin pointer that starts at 0 after reset and advances by one after each such replacement.
- R6: An entry displaced from the victim buffer that is dirty is written out as a one-cycle `mem_wr_valid` pulse, carrying its full word address and data, in the same cycle as the response. A clean displaced entry causes no write.
- R7: Writes mark the line dirty and do not write next-level memory. The dirty flag is carried across swaps and spills.
- R8: A read returns the most recently written value of its address, and a write returns the written word on `resp_rdata`.
- R9: An address is never present in both the direct-mapped array and the victim buffer at the same time.
- R10: While `mem_rd_req` is high and `mem_rd_valid` has not arrived, `mem_rd_req` stays high and `mem_rd_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Loaded word, or the stored word for writes |
| mem_rd_req | output | 1 | Next-level read request, held until mem_rd_valid |
| mem_rd_addr | output | ADDR_W | Next-level read word address |
| mem_rd_valid | input | 1 | Next-level read data valid |
| mem_rd_data | input | DATA_W | Next-level read data |
| mem_wr_valid | output | 1 | One-cycle write-back pulse |
| mem_wr_addr | output | ADDR_W | Write-back word address |
| mem_wr_data | output | DATA_W | Write-back data |

## Verification
A fill can do three things on one clock edge. It installs the fetched word in the direct-mapped array, moves the old direct-mapped line into the victim buffer, and emits a write-back of the buffer entry it overwrites. The response and the write-back therefore appear together. The bench provokes this with streams that reuse one index across more than five tags with frequent stores, so the buffer is full of dirty lines when a fill arrives. Each completion is judged against a reference model of both stores and the round-robin pointer. The model predicts the latency class, the returned word, and whether a write-back happens, with which address and which data.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SWAP = 2'd1,
    ST_FILL = 2'd2
  } dmvc_state_t;
endpackage

// File: rtl/dmvc_l1_store.sv
module dmvc_l1_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic              v_q [LINES];
  logic              d_q [LINES];
  logic [TAG_W-1:0]  t_q [LINES];
  logic [DATA_W-1:0] w_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        v_q[i] <= 1'b0;
        d_q[i] <= 1'b0;
      end
    end else if (we) begin
      v_q[wr_idx] <= 1'b1;
      d_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      t_q[wr_idx] <= wr_tag;
      w_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = v_q[rd_idx];
  assign rd_dirty = d_q[rd_idx];
  assign rd_tag   = t_q[rd_idx];
  assign rd_data  = w_q[rd_idx];
endmodule

// File: rtl/dmvc_vb_store.sv
module dmvc_vb_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int VB_N   = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output logic              hit_dirty,
  output logic [DATA_W-1:0] hit_data,
  input  logic [SLOT_W-1:0] x_slot,
  output logic              x_valid,
  output logic              x_dirty,
  output logic [ADDR_W-1:0] x_addr,
  output logic [DATA_W-1:0] x_data,
  output logic [VB_N-1:0]   valid_vec,
  input  logic              we,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic              v_q [VB_N];
  logic              d_q [VB_N];
  logic [ADDR_W-1:0] a_q [VB_N];
  logic [DATA_W-1:0] w_q [VB_N];
  logic [VB_N-1:0]   match;

  for (genvar g = 0; g < VB_N; g++) begin : g_cam
    assign match[g]     = v_q[g] && (a_q[g] == lk_addr);
    assign valid_vec[g] = v_q[g];
  end

  always_comb begin
    hit_slot = '0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (match[i]) hit_slot = SLOT_W'(i);
    end
  end

  assign hit       = |match;
  assign hit_dirty = d_q[hit_slot];
  assign hit_data  = w_q[hit_slot];
  assign x_valid   = v_q[x_slot];
  assign x_dirty   = d_q[x_slot];
  assign x_addr    = a_q[x_slot];
  assign x_data    = w_q[x_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < VB_N; i++) begin
        v_q[i] <= 1'b0;
        d_q[i] <= 1'b0;
      end
    end else if (we) begin
      v_q[wr_slot] <= wr_valid;
      d_q[wr_slot] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      a_q[wr_slot] <= wr_addr;
      w_q[wr_slot] <= wr_data;
    end
  end
endmodule

// File: rtl/dmvc_vb_pick.sv
module dmvc_vb_pick #(
  parameter int VB_N   = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VB_N-1:0]   valid_vec,
  input  logic              advance,
  output logic [SLOT_W-1:0] slot,
  output logic              full
);
  logic [SLOT_W-1:0] rr_q;
  logic [SLOT_W-1:0] free_slot;

  always_comb begin
    free_slot = '0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_slot = SLOT_W'(i);
    end
  end

  assign full = &valid_vec;
  assign slot = full ? rr_q : free_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (advance && full) begin
      if (rr_q == SLOT_W'(VB_N - 1)) rr_q <= '0;
      else                            rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/dmvc_cache.sv
module dmvc_cache
  import dmvc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int VB_N   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int SLOT_W = (VB_N > 1) ? $clog2(VB_N) : 1;

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction
  function automatic logic [ADDR_W-1:0] f_join(input logic [TAG_W-1:0] t,
                                               input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  dmvc_state_t       st_q;
  logic [ADDR_W-1:0] q_addr;
  logic              q_write;
  logic [DATA_W-1:0] q_wdata;
  logic [ADDR_W-1:0] look_addr;

  logic              l1_v, l1_d;
  logic [TAG_W-1:0]  l1_tag;
  logic [DATA_W-1:0] l1_data;
  logic              l1_we, l1_wd;
  logic [TAG_W-1:0]  l1_wt;
  logic [DATA_W-1:0] l1_wdat;

  logic              vb_hit, vb_h_d;
  logic [SLOT_W-1:0] vb_hslot, pick_slot;
  logic [DATA_W-1:0] vb_h_data, vb_x_data;
  logic              vb_x_v, vb_x_d, pick_full;
  logic [ADDR_W-1:0] vb_x_addr;
  logic [VB_N-1:0]   vb_valid_vec;
  logic              vb_we;
  logic [SLOT_W-1:0] vb_wslot;

  logic l1_hit;
  logic ev_accept, ev_l1_hit, ev_vb_hit, ev_miss, ev_swap, ev_fill, ev_spill, ev_wb;

  assign look_addr = (st_q == ST_IDLE) ? req_addr : q_addr;
  assign l1_hit    = l1_v && (l1_tag == f_tag(look_addr));

  assign ev_accept = (st_q == ST_IDLE) && req_valid;
  assign ev_l1_hit = ev_accept && l1_hit;
  assign ev_vb_hit = ev_accept && !l1_hit && vb_hit;
  assign ev_miss   = ev_accept && !l1_hit && !vb_hit;
  assign ev_swap   = (st_q == ST_SWAP);
  assign ev_fill   = (st_q == ST_FILL) && mem_rd_valid;
  assign ev_spill  = ev_fill && l1_v;
  assign ev_wb     = ev_spill && vb_x_v && vb_x_d;

  dmvc_l1_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_l1 (
    .clk(clk), .rst_n(rst_n), .rd_idx(f_idx(look_addr)),
    .rd_valid(l1_v), .rd_dirty(l1_d), .rd_tag(l1_tag), .rd_data(l1_data),
    .we(l1_we), .wr_idx(f_idx(look_addr)), .wr_dirty(l1_wd),
    .wr_tag(l1_wt), .wr_data(l1_wdat)
  );

  dmvc_vb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VB_N(VB_N), .SLOT_W(SLOT_W)) u_vb (
    .clk(clk), .rst_n(rst_n), .lk_addr(look_addr),
    .hit(vb_hit), .hit_slot(vb_hslot), .hit_dirty(vb_h_d), .hit_data(vb_h_data),
    .x_slot(pick_slot), .x_valid(vb_x_v), .x_dirty(vb_x_d), .x_addr(vb_x_addr),
    .x_data(vb_x_data), .valid_vec(vb_valid_vec),
    .we(vb_we), .wr_slot(vb_wslot), .wr_valid(l1_v), .wr_dirty(l1_d),
    .wr_addr(f_join(l1_tag, f_idx(look_addr))), .wr_data(l1_data)
  );

  dmvc_vb_pick #(.VB_N(VB_N), .SLOT_W(SLOT_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .valid_vec(vb_valid_vec),
    .advance(ev_spill), .slot(pick_slot), .full(pick_full)
  );

  assign vb_we    = ev_swap || ev_spill;
  assign vb_wslot = ev_swap ? vb_hslot : pick_slot;

  always_comb begin
    l1_we   = 1'b0;
    l1_wd   = 1'b0;
    l1_wt   = f_tag(look_addr);
    l1_wdat = l1_data;
    if (ev_l1_hit && req_write) begin
      l1_we   = 1'b1;
      l1_wd   = 1'b1;
      l1_wdat = req_wdata;
    end else if (ev_swap) begin
      l1_we   = 1'b1;
      l1_wd   = vb_h_d | q_write;
      l1_wdat = q_write ? q_wdata : vb_h_data;
    end else if (ev_fill) begin
      l1_we   = 1'b1;
      l1_wd   = q_write;
      l1_wdat = q_write ? q_wdata : mem_rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      resp_valid   <= 1'b0;
      mem_wr_valid <= 1'b0;
    end else begin
      resp_valid   <= ev_l1_hit || ev_swap || ev_fill;
      mem_wr_valid <= ev_wb;
      case (st_q)
        ST_IDLE: if (ev_vb_hit) st_q <= ST_SWAP;
                 else if (ev_miss) st_q <= ST_FILL;
        ST_SWAP: st_q <= ST_IDLE;
        ST_FILL: if (mem_rd_valid) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ev_accept) begin
      q_addr  <= req_addr;
      q_write <= req_write;
      q_wdata <= req_wdata;
    end
    if (ev_l1_hit || ev_swap || ev_fill) resp_rdata <= l1_wdat;
    if (ev_wb) begin
      mem_wr_addr <= vb_x_addr;
      mem_wr_data <= vb_x_data;
    end
  end

  assign req_ready   = (st_q == ST_IDLE);
  assign mem_rd_req  = (st_q == ST_FILL);
  assign mem_rd_addr = q_addr;
endmodule

// File: rtl/dmvc_cache_chk.sv
module dmvc_cache_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_rd_req,
  input logic              mem_rd_valid,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              l1_hit,
  input logic              vb_hit,
  input logic              ev_l1_hit,
  input logic              ev_vb_hit,
  input logic              ev_miss,
  input logic              ev_swap,
  input logic              ev_fill
);
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_hit && vb_hit));

  p_hit_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_hit |=> resp_valid);

  p_swap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vb_hit |=> (ev_swap && !resp_valid && !mem_rd_req));

  p_swap_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> (resp_valid && req_ready));

  p_miss_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (mem_rd_req && !resp_valid));

  p_fill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> resp_valid);

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

  p_wb_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (resp_valid && $past(ev_fill)));

  p_resp_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(ev_l1_hit || ev_swap || ev_fill));
endmodule

bind dmvc_cache dmvc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_wr_valid(mem_wr_valid), .l1_hit(l1_hit), .vb_hit(vb_hit),
  .ev_l1_hit(ev_l1_hit), .ev_vb_hit(ev_vb_hit), .ev_miss(ev_miss),
  .ev_swap(ev_swap), .ev_fill(ev_fill)
);

// File: tb/test_dmvc_cache.sv
module test_dmvc_cache;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 3;
  localparam int VB_N   = 4;
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int WORDS  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] resp_rdata;
  logic              mem_rd_req;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic              mem_rd_valid = 1'b0;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic              mem_wr_valid;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [DATA_W-1:0] mem_wr_data;

  dmvc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .VB_N(VB_N)) i_dmvc_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // flat view of the latest values, and the next-level memory contents
  logic [DATA_W-1:0] tmem [WORDS];
  logic [DATA_W-1:0] bmem [WORDS];
  // reference model of the two stores
  logic              ml_v [LINES];
  logic              ml_d [LINES];
  logic [TAG_W-1:0]  ml_t [LINES];
  logic              mv_v [VB_N];
  logic              mv_d [VB_N];
  logic [ADDR_W-1:0] mv_a [VB_N];
  int                m_rr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_vb_find(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < VB_N; i++) if (mv_v[i] && mv_a[i] == a) return i;
    return -1;
  endfunction

  function automatic int model_slot();
    for (int i = 0; i < VB_N; i++) if (!mv_v[i]) return i;
    return -1;
  endfunction

  // kind: 0 = direct-mapped hit, 1 = victim-buffer hit, 2 = miss in both
  task automatic do_access(input logic w, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] wd,
                           output logic got_wb, output logic [ADDR_W-1:0] got_wb_a,
                           output int kind);
    logic [IDX_W-1:0]  ix;
    logic [TAG_W-1:0]  tg;
    logic              ov, od;
    logic [TAG_W-1:0]  ot;
    int                s, n, lat, cnt;
    logic              exp_wb, rd_seen, bad_addr;
    logic [ADDR_W-1:0] exp_wb_a;
    logic [DATA_W-1:0] exp_wb_d, exp_data, wb_d;
    ix = a[IDX_W-1:0];
    tg = a[ADDR_W-1:IDX_W];
    exp_wb = 1'b0; exp_wb_a = '0; exp_wb_d = '0;
    if (w) tmem[a] = wd;
    exp_data = tmem[a];
    ov = ml_v[ix]; od = ml_d[ix]; ot = ml_t[ix];
    s = model_vb_find(a);
    if (ov && ot == tg) begin
      kind = 0;
      if (w) ml_d[ix] = 1'b1;
    end else if (s >= 0) begin
      kind = 1;
      ml_v[ix] = 1'b1; ml_d[ix] = mv_d[s] | w; ml_t[ix] = tg;
      mv_v[s] = ov; mv_d[s] = od; mv_a[s] = {ot, ix};
    end else begin
      kind = 2;
      if (ov) begin
        s = model_slot();
        if (s < 0) begin
          s = m_rr;
          m_rr = (m_rr + 1) % VB_N;
        end
        if (mv_v[s] && mv_d[s]) begin
          exp_wb = 1'b1; exp_wb_a = mv_a[s]; exp_wb_d = tmem[mv_a[s]];
        end
        mv_v[s] = 1'b1; mv_d[s] = od; mv_a[s] = {ot, ix};
      end
      ml_v[ix] = 1'b1; ml_d[ix] = w; ml_t[ix] = tg;
    end

    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; lat = $urandom_range(0, 2); cnt = 0;
    rd_seen = 1'b0; bad_addr = 1'b0; got_wb = 1'b0; got_wb_a = '0; wb_d = '0;
    while (1) begin
      mem_rd_valid = 1'b0;
      if (mem_wr_valid) begin
        got_wb = 1'b1; got_wb_a = mem_wr_addr; wb_d = mem_wr_data;
        bmem[mem_wr_addr] = mem_wr_data;
      end
      if (resp_valid || n > 40) break;
      if (mem_rd_req) begin
        rd_seen = 1'b1;
        if (mem_rd_addr != a) bad_addr = 1'b1;
        if (cnt == lat) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = bmem[mem_rd_addr];
        end
        cnt++;
      end
      @(negedge clk);
      n++;
    end

    case (kind)
      0: check(n == 1 && !rd_seen, "R2", "hit latency", n, 1);
      1: check(n == 2 && !rd_seen, "R3/R9", "victim hit latency", n, 2);
      default: begin
        check(rd_seen && n == 2 + lat, "R4", "miss latency", n, 2 + lat);
        check(!bad_addr, "R10", "read address held", bad_addr, 0);
      end
    endcase
    check(resp_rdata == exp_data, "R8", "response data", resp_rdata, exp_data);
    check(got_wb == exp_wb, "R6", "write-back presence", got_wb, exp_wb);
    if (got_wb && exp_wb) begin
      check(got_wb_a == exp_wb_a, "R6", "write-back address", got_wb_a, exp_wb_a);
      check(wb_d == exp_wb_d, "R7", "write-back data", wb_d, exp_wb_d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic              wb;
    logic [ADDR_W-1:0] wba;
    int                k;
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) begin
      tmem[i] = DATA_W'($urandom);
      bmem[i] = tmem[i];
    end
    for (int i = 0; i < LINES; i++) begin ml_v[i] = 0; ml_d[i] = 0; ml_t[i] = '0; end
    for (int i = 0; i < VB_N; i++) begin mv_v[i] = 0; mv_d[i] = 0; mv_a[i] = '0; end
    m_rr = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(resp_valid == 1'b0 && mem_rd_req == 1'b0 && mem_wr_valid == 1'b0,
          "R1", "idle outputs in reset", resp_valid | mem_rd_req | mem_wr_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_rd_req && !mem_wr_valid,
          "R1", "idle outputs after reset", req_ready, 1);

    // conflict chain on index 2: tags 1..5 stored dirty
    for (int t = 1; t <= 5; t++) begin
      do_access(1'b1, ADDR_W'((t << IDX_W) | 2), DATA_W'(16'h1000 + t), wb, wba, k);
      if (t == 1) check(k == 2, "R1", "first access misses", k, 2);
      check(!wb, "R7", "no memory write for a store", wb, 0);
    end
    // buffer full: round robin starts at entry 0 holding tag 1
    do_access(1'b0, ADDR_W'((6 << IDX_W) | 2), '0, wb, wba, k);
    check(wb && wba == ADDR_W'((1 << IDX_W) | 2), "R5", "first rr victim", wba, (1 << IDX_W) | 2);
    do_access(1'b0, ADDR_W'((7 << IDX_W) | 2), '0, wb, wba, k);
    check(wb && wba == ADDR_W'((2 << IDX_W) | 2), "R5", "second rr victim", wba, (2 << IDX_W) | 2);
    // swap tag 3 in, then the displaced tag 7 must be a buffer hit
    do_access(1'b0, ADDR_W'((3 << IDX_W) | 2), '0, wb, wba, k);
    check(k == 1, "R3", "swap in", k, 1);
    do_access(1'b0, ADDR_W'((7 << IDX_W) | 2), '0, wb, wba, k);
    check(k == 1, "R3", "displaced line found in buffer", k, 1);
    do_access(1'b0, ADDR_W'((7 << IDX_W) | 2), '0, wb, wba, k);
    check(k == 0, "R2", "repeat hit", k, 0);
    // store into a buffered line, then evict it through the chain
    do_access(1'b1, ADDR_W'((3 << IDX_W) | 2), 16'hBEEF, wb, wba, k);
    check(k == 1, "R7", "store swaps in", k, 1);

    // random traffic over a small tag pool
    for (int i = 0; i < 1500; i++) begin
      logic [ADDR_W-1:0] ra;
      ra = ADDR_W'(($urandom_range(0, 6) << IDX_W) | $urandom_range(0, LINES - 1));
      do_access(($urandom_range(0, 9) < 4), ra, DATA_W'($urandom), wb, wba, k);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule